// File: doc/BRIEF.md
# Overcurrent Trip and Release Detector

This block turns three raw current-fault comparator flags into timed FET shutdowns and then works out on its own when the fault has gone. The three events are discharge overcurrent, charge overcurrent and discharge short circuit. Each event has a 10-bit delay count and a 2-bit time-unit code. An event trips only when its comparator stays asserted for the whole delay. A free-running microsecond tick drives a shared prescaler chain. The chain supplies millisecond, second and minute ticks, so all event timers share one set of dividers.

A tripped discharge-side event opens the discharge FET. A tripped charge event opens the charge FET. Each side then runs its own recovery sequence. The side waits a fixed gap of milliseconds, then raises a probe-enable output for a programmable number of milliseconds. That output drives test current onto the load or charger terminal. At the end of each pulse the block samples that side's release-sense input. If the sense input shows the load or charger has been removed and no event on that side is still qualified, the FET is turned back on and the status flags clear. Otherwise the gap and the pulse repeat.

Top module: `oc_trip_release`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, both FET-off outputs, all three event flags and both probe-enable outputs are low.
- R2: When `us_tick` is high on every cycle and the unit code is 0, a comparator that stays high for D rising clock edges leaves its FET-off output low, and the FET-off output is high after edge D+1. With D=0 the FET-off output is high after the first edge.
- R3: If a comparator drops before its delay has elapsed, the count restarts from zero. No trip occurs, and a later assertion needs the full delay again.
- R4: The unit code selects the tick that the delay counts: 0 microsecond, 1 millisecond (US_PER_MS microseconds), 2 second (MS_PER_S milliseconds), 3 minute (S_PER_MIN seconds). A D-unit delay trips no earlier than (D-1) unit periods plus one cycle and no later than D unit periods plus two cycles.
- R5: Discharge overcurrent and discharge short circuit open only the discharge FET (`dsg_fet_off`). Charge overcurrent opens only the charge FET (`chg_fet_off`).
- R6: Each event flag rises together with its FET-off output when that event trips. The flag stays high until its side is released. A flag never stands high while its side's FET-off output is low.
- R7: After a trip, the faulted side alternates between a low gap of PROBE_GAP_MS milliseconds and a probe pulse of W+1 milliseconds, where W is the 4-bit `probe_width` code (0 gives 1 ms, 15 gives 16 ms). The pulse appears only on that side's probe-enable output.
- R8: At the end of a probe pulse the side is released if its release-sense input is high and none of its events is still qualified. On release the FET-off output falls on the same edge as the probe. Otherwise the FET stays off and another gap begins.
- R9: The discharge and charge sides trip, probe and release independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| dsg_oc_cmp | input | 1 | Discharge overcurrent comparator flag |
| chg_oc_cmp | input | 1 | Charge overcurrent comparator flag |
| dsg_sc_cmp | input | 1 | Discharge short-circuit comparator flag |
| dsg_oc_dly | input | 10 | Discharge overcurrent delay count |
| dsg_oc_unit | input | 2 | Discharge overcurrent delay unit code |
| chg_oc_dly | input | 10 | Charge overcurrent delay count |
| chg_oc_unit | input | 2 | Charge overcurrent delay unit code |
| dsg_sc_dly | input | 10 | Short-circuit delay count |
| dsg_sc_unit | input | 2 | Short-circuit delay unit code |
| probe_width | input | 4 | Probe pulse width code, W+1 ms |
| load_gone | input | 1 | Release sense: load removed from terminal |
| chgr_gone | input | 1 | Release sense: charger removed from terminal |
| dsg_fet_off | output | 1 | Open the discharge FET |
| chg_fet_off | output | 1 | Open the charge FET |
| dsg_oc_flag | output | 1 | Discharge overcurrent fault status |
| chg_oc_flag | output | 1 | Charge overcurrent fault status |
| dsg_sc_flag | output | 1 | Short-circuit fault status |
| load_probe_en | output | 1 | Drive test current onto load terminal |
| chgr_probe_en | output | 1 | Drive test current onto charger terminal |

## Verification
The assertions assume three things about the inputs: `us_tick` is a single-cycle pulse, the delay, unit and width settings do not change while an event is being timed or a probe is running, and a trip of a side's events is taken as already latched. With those assumptions, counter bounds and the tick-chain relations hold. The stimulus changes settings only while both sides are armed and every comparator is low. It drives `us_tick` high on every cycle, so each divided tick is exactly periodic. That makes the probe pulse and gap lengths exact cycle counts, which the bench compares with no tolerance.

// File: rtl/oc_pkg.sv
package oc_pkg;

    typedef enum logic [1:0] {
        UNIT_US  = 2'd0,
        UNIT_MS  = 2'd1,
        UNIT_S   = 2'd2,
        UNIT_MIN = 2'd3
    } unit_e;

    typedef enum logic [1:0] {
        PS_ARMED = 2'd0,
        PS_GAP   = 2'd1,
        PS_PROBE = 2'd2
    } pstate_e;

    localparam int N_EV     = 3;
    localparam int EV_DOC   = 0;
    localparam int EV_COC   = 1;
    localparam int EV_DSC   = 2;

    localparam int N_PATH   = 2;
    localparam int PATH_DSG = 0;
    localparam int PATH_CHG = 1;

    localparam int N_TICK   = 4;

    // Map an event to the side whose FET it opens.
    function automatic int path_of(input int ev);
        return (ev == EV_COC) ? PATH_CHG : PATH_DSG;
    endfunction

endpackage

// File: rtl/oc_timebase.sv
module oc_timebase #(
    parameter int US_PER_MS = 1000,
    parameter int MS_PER_S  = 1000,
    parameter int S_PER_MIN = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       us_tick,
    output logic [3:0] ticks
);

    localparam int MAX_AB = (US_PER_MS > MS_PER_S) ? US_PER_MS : MS_PER_S;
    localparam int MAXDIV = (MAX_AB > S_PER_MIN) ? MAX_AB : S_PER_MIN;
    localparam int CW     = $clog2(MAXDIV + 1);

    function automatic int stage_div(input int k);
        case (k)
            1:       return US_PER_MS;
            2:       return MS_PER_S;
            default: return S_PER_MIN;
        endcase
    endfunction

    assign ticks[0] = us_tick;

    // One prescaler stage per coarser unit: each divides the tick below it.
    for (genvar k = 1; k < 4; k++) begin : g_stage
        localparam int DIV = stage_div(k);

        typedef struct packed {
            logic [CW-1:0] cnt;
            logic          tick;
        } pre_t;

        pre_t pre_d, pre_q;

        always_comb begin
            pre_d      = pre_q;
            pre_d.tick = 1'b0;
            if (ticks[k-1]) begin
                if (pre_q.cnt == CW'(DIV - 1)) begin
                    pre_d.cnt  = '0;
                    pre_d.tick = 1'b1;
                end else begin
                    pre_d.cnt = pre_q.cnt + CW'(1);
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pre_q <= '0;
            else        pre_q <= pre_d;
        end

        assign ticks[k] = pre_q.tick;

        AST_TICK_FROM_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
            ticks[k] |-> $past(ticks[k-1]))
            else $error("coarse tick without finer tick"); // R4
    end

endmodule

// File: rtl/oc_event_qual.sv
module oc_event_qual
    import oc_pkg::*;
#(
    parameter int DLY_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp,
    input  logic [DLY_W-1:0] dly,
    input  unit_e            unit,
    input  logic [3:0]       ticks,
    output logic             trip
);

    typedef struct packed {
        logic [DLY_W-1:0] cnt;
    } qual_t;

    qual_t q_d, q_q;
    logic  unit_tick;

    assign unit_tick = ticks[unit];

    always_comb begin
        q_d = q_q;
        if (!cmp) begin
            q_d.cnt = '0;
        end else if (unit_tick && (q_q.cnt < dly)) begin
            q_d.cnt = q_q.cnt + DLY_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign trip = cmp && (q_q.cnt >= dly);

    AST_QUAL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp |=> (q_q.cnt == '0))
        else $error("delay count kept after comparator dropped"); // R3

    AST_QUAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(trip) && (dly != '0)) |-> $past(cmp))
        else $error("nonzero delay tripped without held comparator"); // R2

endmodule

// File: rtl/oc_release_seq.sv
module oc_release_seq
    import oc_pkg::*;
#(
    parameter int GAP_MS = 256,
    parameter int PW_W   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trip_any,
    input  logic            ms_tick,
    input  logic [PW_W-1:0] width,
    input  logic            gone,
    output logic            fet_off,
    output logic            probe_en,
    output logic            release_now
);

    localparam int PW_MAX = (1 << PW_W);
    localparam int SPAN   = (GAP_MS > PW_MAX) ? GAP_MS : PW_MAX;
    localparam int CW     = $clog2(SPAN + 1);

    typedef struct packed {
        pstate_e       st;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        release_now = 1'b0;
        case (s_q.st)
            PS_ARMED: begin
                if (trip_any) begin
                    s_d.st  = PS_GAP;
                    s_d.cnt = '0;
                end
            end
            PS_GAP: begin
                if (ms_tick) begin
                    if (s_q.cnt >= CW'(GAP_MS - 1)) begin
                        s_d.st  = PS_PROBE;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + CW'(1);
                    end
                end
            end
            PS_PROBE: begin
                if (ms_tick) begin
                    if (s_q.cnt >= CW'(width)) begin
                        s_d.cnt = '0;
                        if (gone && !trip_any) begin
                            s_d.st      = PS_ARMED;
                            release_now = 1'b1;
                        end else begin
                            s_d.st = PS_GAP;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + CW'(1);
                    end
                end
            end
            default: begin
                s_d.st  = PS_ARMED;
                s_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: PS_ARMED, cnt: '0};
        else        s_q <= s_d;
    end

    assign fet_off  = (s_q.st != PS_ARMED);
    assign probe_en = (s_q.st == PS_PROBE);

    AST_TRIP_OPENS_FET: assert property (@(posedge clk) disable iff (!rst_n)
        trip_any |=> fet_off)
        else $error("qualified event left FET on"); // R5

    AST_RELEASE_SENSED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fet_off) |-> ($past(gone) && $past(probe_en)))
        else $error("FET re-enabled without sensed removal at probe end"); // R8

    AST_PROBE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(probe_en) |-> ($past(fet_off) && $past(ms_tick)))
        else $error("probe started outside a fault gap"); // R7

endmodule

// File: rtl/oc_trip_release.sv
module oc_trip_release
    import oc_pkg::*;
#(
    parameter int US_PER_MS    = 1000,
    parameter int MS_PER_S     = 1000,
    parameter int S_PER_MIN    = 60,
    parameter int PROBE_GAP_MS = 256,
    parameter int DLY_W        = 10,
    parameter int PW_W         = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick,
    input  logic             dsg_oc_cmp,
    input  logic             chg_oc_cmp,
    input  logic             dsg_sc_cmp,
    input  logic [DLY_W-1:0] dsg_oc_dly,
    input  logic [1:0]       dsg_oc_unit,
    input  logic [DLY_W-1:0] chg_oc_dly,
    input  logic [1:0]       chg_oc_unit,
    input  logic [DLY_W-1:0] dsg_sc_dly,
    input  logic [1:0]       dsg_sc_unit,
    input  logic [PW_W-1:0]  probe_width,
    input  logic             load_gone,
    input  logic             chgr_gone,
    output logic             dsg_fet_off,
    output logic             chg_fet_off,
    output logic             dsg_oc_flag,
    output logic             chg_oc_flag,
    output logic             dsg_sc_flag,
    output logic             load_probe_en,
    output logic             chgr_probe_en
);

    logic [3:0]        ticks;
    logic              cmp_v   [N_EV];
    logic [DLY_W-1:0]  dly_v   [N_EV];
    unit_e             unit_v  [N_EV];
    logic [N_EV-1:0]   trip_v;
    logic [N_PATH-1:0] path_trip;
    logic [N_PATH-1:0] gone_v;
    logic [N_PATH-1:0] fet_v;
    logic [N_PATH-1:0] probe_v;
    logic [N_PATH-1:0] rel_v;

    oc_timebase #(
        .US_PER_MS (US_PER_MS),
        .MS_PER_S  (MS_PER_S),
        .S_PER_MIN (S_PER_MIN)
    ) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .us_tick (us_tick),
        .ticks   (ticks)
    );

    assign cmp_v[EV_DOC]  = dsg_oc_cmp;
    assign cmp_v[EV_COC]  = chg_oc_cmp;
    assign cmp_v[EV_DSC]  = dsg_sc_cmp;
    assign dly_v[EV_DOC]  = dsg_oc_dly;
    assign dly_v[EV_COC]  = chg_oc_dly;
    assign dly_v[EV_DSC]  = dsg_sc_dly;
    assign unit_v[EV_DOC] = unit_e'(dsg_oc_unit);
    assign unit_v[EV_COC] = unit_e'(chg_oc_unit);
    assign unit_v[EV_DSC] = unit_e'(dsg_sc_unit);

    for (genvar e = 0; e < N_EV; e++) begin : g_event
        oc_event_qual #(
            .DLY_W (DLY_W)
        ) u_qual (
            .clk   (clk),
            .rst_n (rst_n),
            .cmp   (cmp_v[e]),
            .dly   (dly_v[e]),
            .unit  (unit_v[e]),
            .ticks (ticks),
            .trip  (trip_v[e])
        );
    end

    assign path_trip[PATH_DSG] = trip_v[EV_DOC] | trip_v[EV_DSC];
    assign path_trip[PATH_CHG] = trip_v[EV_COC];
    assign gone_v[PATH_DSG]    = load_gone;
    assign gone_v[PATH_CHG]    = chgr_gone;

    for (genvar p = 0; p < N_PATH; p++) begin : g_path
        oc_release_seq #(
            .GAP_MS (PROBE_GAP_MS),
            .PW_W   (PW_W)
        ) u_seq (
            .clk         (clk),
            .rst_n       (rst_n),
            .trip_any    (path_trip[p]),
            .ms_tick     (ticks[1]),
            .width       (probe_width),
            .gone        (gone_v[p]),
            .fet_off     (fet_v[p]),
            .probe_en    (probe_v[p]),
            .release_now (rel_v[p])
        );
    end

    typedef struct packed {
        logic [N_EV-1:0] flag;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_EV; i++) begin
            st_d.flag[i] = trip_v[i] | (st_q.flag[i] & ~rel_v[path_of(i)]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dsg_fet_off   = fet_v[PATH_DSG];
    assign chg_fet_off   = fet_v[PATH_CHG];
    assign load_probe_en = probe_v[PATH_DSG];
    assign chgr_probe_en = probe_v[PATH_CHG];
    assign dsg_oc_flag   = st_q.flag[EV_DOC];
    assign chg_oc_flag   = st_q.flag[EV_COC];
    assign dsg_sc_flag   = st_q.flag[EV_DSC];

    AST_DSG_FLAG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (dsg_oc_flag | dsg_sc_flag) |-> dsg_fet_off)
        else $error("discharge flag with discharge FET on"); // R6

    AST_CHG_FLAG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        chg_oc_flag |-> chg_fet_off)
        else $error("charge flag with charge FET on"); // R6

endmodule

// File: tb/oc_trip_release_tb.sv
module oc_trip_release_tb;

    localparam int P_MS  = 4;
    localparam int P_S   = P_MS * 5;
    localparam int P_MIN = P_S * 3;
    localparam int GAP   = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b1;
    logic       dsg_oc_cmp = 1'b0, chg_oc_cmp = 1'b0, dsg_sc_cmp = 1'b0;
    logic [9:0] dsg_oc_dly = '0, chg_oc_dly = '0, dsg_sc_dly = '0;
    logic [1:0] dsg_oc_unit = '0, chg_oc_unit = '0, dsg_sc_unit = '0;
    logic [3:0] probe_width = '0;
    logic       load_gone = 1'b0, chgr_gone = 1'b0;
    logic       dsg_fet_off, chg_fet_off, dsg_oc_flag, chg_oc_flag, dsg_sc_flag;
    logic       load_probe_en, chgr_probe_en;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    oc_trip_release #(
        .US_PER_MS    (4),
        .MS_PER_S     (5),
        .S_PER_MIN    (3),
        .PROBE_GAP_MS (GAP)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .us_tick       (us_tick),
        .dsg_oc_cmp    (dsg_oc_cmp),
        .chg_oc_cmp    (chg_oc_cmp),
        .dsg_sc_cmp    (dsg_sc_cmp),
        .dsg_oc_dly    (dsg_oc_dly),
        .dsg_oc_unit   (dsg_oc_unit),
        .chg_oc_dly    (chg_oc_dly),
        .chg_oc_unit   (chg_oc_unit),
        .dsg_sc_dly    (dsg_sc_dly),
        .dsg_sc_unit   (dsg_sc_unit),
        .probe_width   (probe_width),
        .load_gone     (load_gone),
        .chgr_gone     (chgr_gone),
        .dsg_fet_off   (dsg_fet_off),
        .chg_fet_off   (chg_fet_off),
        .dsg_oc_flag   (dsg_oc_flag),
        .chg_oc_flag   (chg_oc_flag),
        .dsg_sc_flag   (dsg_sc_flag),
        .load_probe_en (load_probe_en),
        .chgr_probe_en (chgr_probe_en)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input string what, input int act,
                             input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    function automatic logic fet(input int p);
        return (p == 0) ? dsg_fet_off : chg_fet_off;
    endfunction

    function automatic logic prb(input int p);
        return (p == 0) ? load_probe_en : chgr_probe_en;
    endfunction

    task automatic wait_probe(input int p, input logic lvl, output int n);
        n = 0;
        while (prb(p) !== lvl && n < 2000) begin
            step(1);
            n++;
        end
    endtask

    task automatic wait_released(input int p, input string req);
        int n = 0;
        while (fet(p) === 1'b1 && n < 2000) begin
            step(1);
            n++;
        end
        chk(req, "side released", int'(fet(p)), 0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        step(3);
        chk("R1", "outputs in reset",
            int'({dsg_fet_off, chg_fet_off, dsg_oc_flag, chg_oc_flag, dsg_sc_flag,
                  load_probe_en, chgr_probe_en}), 0);
        rst_n = 1'b1;
        step(1);
        chk("R1", "outputs after reset",
            int'({dsg_fet_off, chg_fet_off, dsg_oc_flag, chg_oc_flag, dsg_sc_flag,
                  load_probe_en, chgr_probe_en}), 0);
    endtask

    task automatic test_us_delay();
        int n;
        probe_width = 4'd2;
        dsg_oc_dly  = 10'd5;
        dsg_oc_unit = 2'd0;
        dsg_oc_cmp  = 1'b1;
        step(5);
        chk("R2", "dsg FET before delay end", int'(dsg_fet_off), 0);
        step(1);
        chk("R2", "dsg FET after delay", int'(dsg_fet_off), 1);
        chk("R6", "dsg_oc flag set", int'(dsg_oc_flag), 1);
        chk("R5", "charge FET untouched", int'(chg_fet_off), 0);
        chk("R6", "other flags clear", int'({chg_oc_flag, dsg_sc_flag}), 0);
        dsg_oc_cmp = 1'b0;
        load_gone  = 1'b1;
        wait_probe(0, 1'b1, n);
        chk("R7", "no charger probe", int'(chgr_probe_en), 0);
        wait_probe(0, 1'b0, n);
        chk("R7", "probe width W=2", n, 3 * P_MS);
        chk("R8", "released at probe end", int'(dsg_fet_off), 0);
        chk("R6", "flag cleared on release", int'(dsg_oc_flag), 0);
        load_gone = 1'b0;
        step(2);
    endtask

    task automatic test_retry();
        int n;
        probe_width = 4'd1;
        chg_oc_dly  = 10'd0;
        chg_oc_unit = 2'd0;
        chg_oc_cmp  = 1'b1;
        step(1);
        chk("R2", "zero delay trips on first edge", int'(chg_fet_off), 1);
        chk("R5", "discharge FET untouched", int'(dsg_fet_off), 0);
        chg_oc_cmp = 1'b0;
        wait_probe(1, 1'b1, n);
        wait_probe(1, 1'b0, n);
        chk("R7", "probe width W=1", n, 2 * P_MS);
        chk("R8", "held off without sense", int'(chg_fet_off), 1);
        chk("R6", "chg flag held", int'(chg_oc_flag), 1);
        wait_probe(1, 1'b1, n);
        chk("R7", "gap length", n, GAP * P_MS);
        chgr_gone = 1'b1;
        wait_probe(1, 1'b0, n);
        chk("R8", "released on second probe", int'(chg_fet_off), 0);
        chgr_gone = 1'b0;
        step(2);
    endtask

    task automatic test_glitch();
        dsg_sc_dly  = 10'd6;
        dsg_sc_unit = 2'd0;
        dsg_sc_cmp  = 1'b1;
        step(5);
        dsg_sc_cmp = 1'b0;
        step(1);
        chk("R3", "no trip after short pulse", int'(dsg_fet_off), 0);
        dsg_sc_cmp = 1'b1;
        step(6);
        chk("R3", "full delay needed again", int'(dsg_fet_off), 0);
        step(1);
        chk("R3", "trip after full delay", int'(dsg_fet_off), 1);
        chk("R6", "only sc flag", int'({dsg_oc_flag, dsg_sc_flag}), 1);
        dsg_sc_cmp = 1'b0;
        load_gone  = 1'b1;
        wait_released(0, "R8");
        chk("R6", "sc flag cleared", int'(dsg_sc_flag), 0);
        load_gone = 1'b0;
        step(2);
    endtask

    task automatic test_held_event();
        int n;
        probe_width = 4'd0;
        dsg_oc_dly  = 10'd0;
        dsg_oc_unit = 2'd0;
        dsg_oc_cmp  = 1'b1;
        load_gone   = 1'b1;
        step(1);
        wait_probe(0, 1'b1, n);
        wait_probe(0, 1'b0, n);
        chk("R7", "probe width W=0", n, P_MS);
        chk("R8", "no release while event held", int'(dsg_fet_off), 1);
        dsg_oc_cmp = 1'b0;
        wait_probe(0, 1'b1, n);
        wait_probe(0, 1'b0, n);
        chk("R8", "release once event gone", int'(dsg_fet_off), 0);
        load_gone = 1'b0;
        step(2);
    endtask

    task automatic test_units();
        int per;
        for (int u = 1; u < 4; u++) begin
            int n = 0;
            per = (u == 1) ? P_MS : (u == 2) ? P_S : P_MIN;
            dsg_oc_dly  = 10'd2;
            dsg_oc_unit = 2'(u);
            dsg_oc_cmp  = 1'b1;
            while (dsg_fet_off !== 1'b1 && n < 1000) begin
                step(1);
                n++;
            end
            chk_range("R4", $sformatf("trip latency unit %0d", u), n, per + 1, 2 * per + 2);
            dsg_oc_cmp = 1'b0;
            load_gone  = 1'b1;
            wait_released(0, "R4");
            load_gone = 1'b0;
            step(2);
        end
        dsg_oc_unit = 2'd0;
    endtask

    task automatic test_independent();
        probe_width = 4'd0;
        dsg_oc_dly  = 10'd1;
        chg_oc_dly  = 10'd1;
        dsg_oc_cmp  = 1'b1;
        chg_oc_cmp  = 1'b1;
        step(2);
        chk("R9", "both sides tripped", int'({dsg_fet_off, chg_fet_off}), 3);
        dsg_oc_cmp = 1'b0;
        chg_oc_cmp = 1'b0;
        load_gone  = 1'b1;
        wait_released(0, "R9");
        chk("R9", "charge side still off", int'(chg_fet_off), 1);
        chk("R9", "charge flag still set", int'(chg_oc_flag), 1);
        chgr_gone = 1'b1;
        wait_released(1, "R9");
        load_gone = 1'b0;
        chgr_gone = 1'b0;
        step(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_us_delay();
        test_retry();
        test_glitch();
        test_held_event();
        test_units();
        test_independent();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule